// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that steps once per falling edge of a timer clock input. A gate input enables, restarts or triggers the count. A single output is shaped according to one of six counting modes: pulse on terminal count, retriggerable one-shot, rate generator, square wave, software-triggered strobe and gate-triggered strobe. The count runs in plain binary or in four-decade BCD. A written count of zero stands for the largest count the selected radix allows.

Configuration arrives as two strobes. A mode write carries a 3-bit mode code and a radix bit. A count write carries the initial count. The timer clock and gate are treated as level inputs sampled by the system clock `clk`. They are expected to be synchronous to it, and the timer clock must stay high and low for at least one `clk` cycle each. Every step of the counter happens in the `clk` cycle in which a falling timer-clock edge is seen. That cycle is called a tick below.

The channel reports whether a written count is still waiting to reach the counting element. Until the channel has been programmed, its output carries no meaning.

Top module: `tmr_channel`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out` is low and `pending` is low.
- R2: A tick is a `clk` cycle in which `tclk` is low and was high in the previous cycle. Counting, loading and the terminal-count output changes occur only on ticks. Holding `tclk` at a steady level leaves `out` unchanged.
- R3: A count write raises `pending` in the next cycle. `pending` falls on the tick that copies the written value into the counter.
- R4: Mode code 0, terminal-count pulse. A mode write or a count write drives `out` low. The first tick after the count write loads the count N. `out` then goes high on the (N+1)th tick and stays high. Ticks with `gate` low do not count.
- R5: Mode code 1, retriggerable one-shot. A rising edge on `gate` arms a trigger. The next tick loads N and drives `out` low, and `out` returns high N ticks later. A trigger that lands on the tick where the count would reach zero reloads the count, and `out` stays low for a further N ticks.
- R6: Mode code 2, rate generator, for N of 2 or more. The first tick loads N. `out` then has a period of N ticks and is low for exactly one tick when the count is one. `gate` low forces `out` high in the next cycle and halts counting. The first tick with `gate` high reloads N.
- R7: Mode code 3, square wave. The period is N ticks, with `out` high for ceil(N/2) ticks and low for floor(N/2) ticks. A low `gate` acts as in R6.
- R8: Mode code 4, software strobe. `out` stays high, except on the (N+1)th tick after the count write, when it is low for exactly one tick.
- R9: Mode code 5, gate strobe. A rising edge on `gate` loads N on the next tick, and `out` is low for exactly the Nth tick after that load.
- R10: A written count of 0 behaves as 65536 in binary and as 10000 in BCD.
- R11: With `cfg_bcd` set, each 4-bit digit steps from 0 to 9 with a borrow into the next digit. Count 0x0100 therefore spans 100 ticks, and 0x0011 in square-wave mode gives 6 high ticks and 5 low ticks.
- R12: Mode codes 6 and 7 behave as codes 2 and 3.
- R13: In rate and square-wave modes, a count written while counting takes effect at the next reload. `pending` stays high until that reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk | input | 1 | Timer clock; each falling edge is a tick |
| gate | input | 1 | Count enable, restart or trigger, depending on mode |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_bcd | input | 1 | 1 selects BCD counting, 0 selects binary |
| cnt_we | input | 1 | Count write strobe |
| cnt_val | input | 16 | Initial count |
| out | output | 1 | Shaped timer output |
| pending | output | 1 | Written count not yet moved into the counter |

## Verification
Several functions can fall on the same tick. The one that matters most is a retrigger in one-shot mode arriving on the tick that would take the count to zero. The bench lets a pulse run down to a count of one, then pulses `gate` low and high so that the trigger is held for that very tick. It then expects `out` to stay low for the full N ticks that follow, with no high glitch. A second overlap is a count write while a rate-generator period is running. There the expected `pending` level and pulse spacing show whether the old period finishes before the new count takes over.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmr_mode_e;

    typedef struct packed {
        logic load;
        logic dec;
    } cnt_cmd_t;

    // codes 6 and 7 alias the periodic modes
    function automatic tmr_mode_e norm_mode(input logic [2:0] code);
        case (code)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return tmr_mode_e'(code);
        endcase
    endfunction

    function automatic logic idle_level(input tmr_mode_e m);
        return m != M_TERM;
    endfunction

    function automatic logic [3:0] digit_dec(input logic [3:0] d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

    function automatic logic [3:0] digit_half(input logic [3:0] d, input logic upper_odd);
        return {1'b0, d[3:1]} + (upper_odd ? 4'd5 : 4'd0);
    endfunction

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic tclk,
    input  logic gate,
    input  logic clr,
    output logic tick,
    output logic trig
);
    logic tclk_q, gate_q, hold_q, rise;

    assign tick = tclk_q & ~tclk;
    assign rise = gate & ~gate_q;
    assign trig = rise | hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_q <= 1'b0;
            gate_q <= 1'b1;
            hold_q <= 1'b0;
        end else begin
            tclk_q <= tclk;
            gate_q <= gate;
            if (clr || tick)
                hold_q <= 1'b0;
            else if (rise)
                hold_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_cmd_t     cmd,
    input  logic [W-1:0] ld_val,
    input  logic         bcd,
    output logic         cnt_one,
    output logic         nxt_zero,
    output logic         nxt_one,
    output logic         nxt_low
);
    localparam int NDIG = W / 4;

    logic [W-1:0] cnt_q, half_q;
    logic [W-1:0] nv, nv_bin, nv_bcd;
    logic [W-1:0] half_bin, half_bcd;
    logic [NDIG-1:0] brw;
    logic ld_zero;

    assign ld_zero = (ld_val == '0);
    assign brw[0]  = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] d;
        assign d = cnt_q[4*g +: 4];
        assign nv_bcd[4*g +: 4] = brw[g] ? digit_dec(d) : d;
        if (g < NDIG - 1) begin : g_mid
            assign brw[g+1] = brw[g] & (d == 4'd0);
            assign half_bcd[4*g +: 4] = digit_half(ld_val[4*g +: 4], ld_val[4*(g+1)]);
        end else begin : g_top
            assign half_bcd[4*g +: 4] = ld_zero ? 4'd5 : digit_half(ld_val[4*g +: 4], 1'b0);
        end
    end

    assign nv_bin   = cnt_q - W'(1);
    assign half_bin = ld_zero ? {1'b1, {(W-1){1'b0}}} : (ld_val >> 1);
    assign nv       = bcd ? nv_bcd : nv_bin;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= '0;
        end else if (cmd.load) begin
            cnt_q  <= ld_val;
            half_q <= bcd ? half_bcd : half_bin;
        end else if (cmd.dec) begin
            cnt_q  <= nv;
        end
    end

    assign cnt_one  = (cnt_q == W'(1));
    assign nxt_zero = (nv == '0);
    assign nxt_one  = (nv == W'(1));
    assign nxt_low  = (nv != '0) && (nv <= half_q);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_mode,
    input  logic         cfg_bcd,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_val,
    input  logic         tick,
    input  logic         trig,
    input  logic         gate,
    input  logic         cnt_one,
    input  logic         nxt_zero,
    input  logic         nxt_one,
    input  logic         nxt_low,
    output cnt_cmd_t     cmd,
    output logic [W-1:0] init_q,
    output logic         bcd_q,
    output logic         out,
    output logic         pending
);
    tmr_mode_e mode_q, new_mode;
    logic out_q, run_q, armed_q, pend_q;
    logic out_n, run_n, pend_n, do_load, do_dec;
    logic periodic, strobe;

    assign new_mode = norm_mode(cfg_mode);
    assign periodic = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    assign strobe   = (mode_q == M_SWSTB) || (mode_q == M_HWSTB);

    always_comb begin
        do_load = 1'b0;
        do_dec  = 1'b0;
        out_n   = out_q;
        run_n   = run_q;
        pend_n  = pend_q;
        if (periodic && !gate) begin
            out_n = 1'b1;
            run_n = 1'b0;
        end else if (tick) begin
            if (strobe)
                out_n = 1'b1;
            case (mode_q)
                M_TERM, M_SWSTB: begin
                    if (!run_q && pend_q) begin
                        do_load = 1'b1;
                        run_n   = 1'b1;
                        pend_n  = 1'b0;
                    end else if (run_q && gate) begin
                        do_dec = 1'b1;
                        if (nxt_zero) begin
                            run_n = 1'b0;
                            out_n = (mode_q == M_TERM);
                        end
                    end
                end
                M_ONESHOT, M_HWSTB: begin
                    if (trig && armed_q) begin
                        do_load = 1'b1;
                        run_n   = 1'b1;
                        pend_n  = 1'b0;
                        if (mode_q == M_ONESHOT)
                            out_n = 1'b0;
                    end else if (run_q) begin
                        do_dec = 1'b1;
                        if (nxt_zero) begin
                            run_n = 1'b0;
                            out_n = (mode_q == M_ONESHOT);
                        end
                    end
                end
                default: begin
                    if (!run_q || cnt_one) begin
                        if (armed_q) begin
                            do_load = 1'b1;
                            run_n   = 1'b1;
                            pend_n  = 1'b0;
                            out_n   = 1'b1;
                        end
                    end else begin
                        do_dec = 1'b1;
                        out_n  = (mode_q == M_RATE) ? !nxt_one : !nxt_low;
                    end
                end
            endcase
        end
    end

    assign cmd.load = do_load & ~cfg_we;
    assign cmd.dec  = do_dec & ~cfg_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_TERM;
            bcd_q   <= 1'b0;
            out_q   <= 1'b0;
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            init_q  <= '0;
        end else if (cfg_we) begin
            mode_q  <= new_mode;
            bcd_q   <= cfg_bcd;
            out_q   <= idle_level(new_mode);
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            out_q  <= out_n;
            run_q  <= run_n;
            pend_q <= pend_n;
            if (cnt_we) begin
                init_q  <= cnt_val;
                armed_q <= 1'b1;
                pend_q  <= 1'b1;
                if (mode_q == M_TERM || mode_q == M_SWSTB)
                    run_q <= 1'b0;
                if (mode_q == M_TERM)
                    out_q <= 1'b0;
            end
        end
    end

    assign out     = out_q;
    assign pending = pend_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tclk,
    input  logic         gate,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_mode,
    input  logic         cfg_bcd,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_val,
    output logic         out,
    output logic         pending
);
    logic         tick, trig;
    logic         cnt_one, nxt_zero, nxt_one, nxt_low;
    logic         bcd_w;
    logic [W-1:0] init_w;
    cnt_cmd_t     cmd;

    tmr_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .tclk (tclk),
        .gate (gate),
        .clr  (cfg_we),
        .tick (tick),
        .trig (trig)
    );

    tmr_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_bcd  (cfg_bcd),
        .cnt_we   (cnt_we),
        .cnt_val  (cnt_val),
        .tick     (tick),
        .trig     (trig),
        .gate     (gate),
        .cnt_one  (cnt_one),
        .nxt_zero (nxt_zero),
        .nxt_one  (nxt_one),
        .nxt_low  (nxt_low),
        .cmd      (cmd),
        .init_q   (init_w),
        .bcd_q    (bcd_w),
        .out      (out),
        .pending  (pending)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ld_val   (init_w),
        .bcd      (bcd_w),
        .cnt_one  (cnt_one),
        .nxt_zero (nxt_zero),
        .nxt_one  (nxt_one),
        .nxt_low  (nxt_low)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cfg_we,
    input logic [2:0] cfg_mode,
    input logic      cnt_we,
    input logic      gate,
    input logic      tick,
    input logic      trig,
    input tmr_mode_e mode,
    input logic      out,
    input logic      pending
);
    AST_TERM_CFG_LOW: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_mode == 3'd0 |=> !out); // R4

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        cnt_we && !cfg_we |=> pending); // R3

    AST_PEND_CLR_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) && !$past(cfg_we) |-> $past(tick)); // R3

    AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RATE || mode == M_SQUARE) && !gate && !cfg_we |=> out); // R6

    AST_RATE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        mode == M_RATE && !out && tick && !cfg_we |=> out); // R6

    AST_RETRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
        mode == M_ONESHOT && !out && tick && trig && !cfg_we |=> !out); // R5

    AST_TERM_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        mode == M_TERM && $rose(out) |-> $past(tick)); // R4

    AST_OUT_STABLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick && !cfg_we && !cnt_we && gate |=> $stable(out)); // R2
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .cnt_we   (cnt_we),
    .gate     (gate),
    .tick     (tick),
    .trig     (trig),
    .mode     (u_ctrl.mode_q),
    .out      (out),
    .pending  (pending)
);

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tclk = 1'b1;
    logic         gate = 1'b1;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_mode = 3'd0;
    logic         cfg_bcd = 1'b0;
    logic         cnt_we = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         out, pending;

    always #5 clk = ~clk;

    tmr_channel #(.W(W)) u0 (
        .clk(clk), .rst(rst), .tclk(tclk), .gate(gate),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
        .cnt_we(cnt_we), .cnt_val(cnt_val), .out(out), .pending(pending)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    item_t cur;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    event  smp;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops the expected output level for each tick
    always begin
        @(smp);
        if (q.size() == 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: got %b expected <none>", out);
        end else begin
            cur = q.pop_front();
            chk(out, cur.exp, cur.req);
        end
    end

    task automatic tk(input logic e, input string r);
        q.push_back('{exp: e, req: r});
        tclk = 1'b0;
        @(negedge clk);
        ->smp;
        tclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic tkn(input int n, input logic e, input string r);
        for (int i = 0; i < n; i++) tk(e, r);
    endtask

    task automatic cfg(input logic [2:0] m, input logic b);
        cfg_mode = m;
        cfg_bcd  = b;
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic ld(input logic [W-1:0] v);
        cnt_val = v;
        cnt_we  = 1'b1;
        @(negedge clk);
        cnt_we  = 1'b0;
    endtask

    task automatic trig_pulse();
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got running expected finished");
            done = 1'b1;
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out, 1'b0, "R1");
        chk(pending, 1'b0, "R1");
        rst = 1'b0;
        @(negedge clk);
        chk(out, 1'b0, "R1");
        chk(pending, 1'b0, "R1");

        // R4 terminal-count pulse, N=5, with an idle stretch for R2
        cfg(3'd0, 1'b0);
        chk(out, 1'b0, "R4");
        ld(16'd5);
        chk(pending, 1'b1, "R3");
        tk(1'b0, "R4");
        chk(pending, 1'b0, "R3");
        tkn(2, 1'b0, "R4");
        repeat (10) @(negedge clk);
        chk(out, 1'b0, "R2");
        tkn(2, 1'b0, "R4");
        tk(1'b1, "R4");
        tkn(2, 1'b1, "R4");
        ld(16'd3);
        chk(out, 1'b0, "R4");
        tk(1'b0, "R4");
        gate = 1'b0;
        tkn(3, 1'b0, "R4 gate pause");
        gate = 1'b1;
        tkn(2, 1'b0, "R4");
        tk(1'b1, "R4");

        // R5 retriggerable one-shot, N=4
        cfg(3'd1, 1'b0);
        chk(out, 1'b1, "R5");
        ld(16'd4);
        tkn(2, 1'b1, "R5 no trigger");
        chk(pending, 1'b1, "R3");
        trig_pulse();
        tk(1'b0, "R5");
        chk(pending, 1'b0, "R3");
        tkn(3, 1'b0, "R5");
        tkn(2, 1'b1, "R5");
        trig_pulse();
        tkn(4, 1'b0, "R5");
        trig_pulse();
        tk(1'b0, "R5 retrigger at terminal");
        tkn(3, 1'b0, "R5");
        tk(1'b1, "R5");

        // R6 / R12 rate generator via code 6, N=4
        cfg(3'd6, 1'b0);
        chk(out, 1'b1, "R12");
        ld(16'd4);
        tkn(3, 1'b1, "R6");
        tk(1'b0, "R6");
        tkn(3, 1'b1, "R6");
        tk(1'b0, "R6");
        gate = 1'b0;
        @(negedge clk);
        chk(out, 1'b1, "R6 gate forces high");
        tkn(2, 1'b1, "R6 halted");
        gate = 1'b1;
        tkn(3, 1'b1, "R6 reload");
        tk(1'b0, "R6");
        // R13 count write mid-period
        tk(1'b1, "R13");
        ld(16'd3);
        chk(pending, 1'b1, "R13");
        tkn(2, 1'b1, "R13");
        tk(1'b0, "R13");
        chk(pending, 1'b1, "R13");
        tk(1'b1, "R13");
        chk(pending, 1'b0, "R13");
        tk(1'b1, "R13");
        tk(1'b0, "R13");
        tk(1'b1, "R13");

        // R7 square wave, N=5 then N=4 via code 7
        cfg(3'd3, 1'b0);
        ld(16'd5);
        tkn(3, 1'b1, "R7");
        tkn(2, 1'b0, "R7");
        tkn(3, 1'b1, "R7");
        tkn(2, 1'b0, "R7");
        cfg(3'd7, 1'b0);
        ld(16'd4);
        tkn(2, 1'b1, "R12");
        tkn(2, 1'b0, "R12");
        tkn(2, 1'b1, "R7");
        tkn(2, 1'b0, "R7");

        // R8 software strobe, N=3
        cfg(3'd4, 1'b0);
        chk(out, 1'b1, "R8");
        ld(16'd3);
        tkn(3, 1'b1, "R8");
        tk(1'b0, "R8");
        tkn(2, 1'b1, "R8");

        // R9 gate strobe, N=2
        cfg(3'd5, 1'b0);
        ld(16'd2);
        tk(1'b1, "R9 no trigger");
        trig_pulse();
        tkn(2, 1'b1, "R9");
        tk(1'b0, "R9");
        tkn(2, 1'b1, "R9");

        // R11 BCD decrement and halving
        cfg(3'd0, 1'b1);
        ld(16'h0100);
        tk(1'b0, "R11");
        tkn(99, 1'b0, "R11");
        tk(1'b1, "R11");
        cfg(3'd3, 1'b1);
        ld(16'h0011);
        tkn(6, 1'b1, "R11 square high");
        tkn(5, 1'b0, "R11 square low");
        tk(1'b1, "R11");

        // R10 zero as largest count, BCD then binary
        cfg(3'd0, 1'b1);
        ld(16'h0000);
        tk(1'b0, "R10");
        tkn(9999, 1'b0, "R10 bcd");
        tk(1'b1, "R10 bcd");
        cfg(3'd0, 1'b0);
        ld(16'h0000);
        tk(1'b0, "R10");
        tkn(65535, 1'b0, "R10 binary");
        tk(1'b1, "R10 binary");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: got %0d left expected 0", q.size());
        end
        if (!done) begin
            done = 1'b1;
            report();
            $finish;
        end
    end
endmodule